// File: doc/BRIEF.md
# Multiported Register File with Write Bypass

This block holds a bank of general-purpose registers for a wide-issue datapath. Every entry stores a data word together with a single poison flag that travels with it. Several read ports look up entries combinationally. Several write ports update entries on the rising clock edge, and each write port has its own enable, address, data and poison inputs. The number of entries, the word width and both port counts are parameters. By default the block has 32 entries of 64 bits, nine read ports and four write ports.

A value that is being written is forwarded straight to any read port that asks for the same entry in that cycle. A consumer therefore never sees a stale value while a write to its entry is in flight. The block does not arbitrate between writers. The issue logic outside the block is expected to enable at most one writer per entry in each cycle. If that rule is broken, the block settles the clash in a fixed way and raises a flag for that cycle, so the fault can be seen.

Top module: `regfile_mp`

## Requirements
- R1: While reset (`rstN` low) is asserted, every entry is cleared to data zero and poison zero. After reset is released, a read of any entry returns zero data and zero poison.
- R2: A write port whose enable is high stores its data and poison into the entry at its address on the rising clock edge. A read issued in the next cycle returns that data and poison.
- R3: A write port whose enable is low changes no entry and is never forwarded to any read port, whatever its address, data or poison inputs are.
- R4: When no enabled write port targets a read port's address, that read port returns the stored data and poison of the addressed entry in the same cycle, with no clock edge in between.
- R5: When an enabled write port targets a read port's address, that read port returns the write data and poison in the same cycle.
- R6: When two or more enabled write ports target the same entry, the entry takes the data and poison of the highest-numbered of those ports.
- R7: When a read port's address matches several enabled write ports, the forwarded value comes from the highest-numbered of those ports, which is the same port that R6 picks.
- R8: `wrConflict` is high in exactly those cycles in which at least two enabled write ports carry the same address. A disabled port never counts towards a clash.
- R9: The poison bit is stored and returned per entry, independently of the data. Writing poison zero clears a poison bit that was set earlier.
- R10: All read ports work independently. In one cycle, each port returns the value for its own address, even when every port uses a different address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset; clears all entries |
| wrEn | input | WR_PORTS | Write enable, one bit per write port |
| wrAddr | input | WR_PORTS*ADDR_W | Write addresses; port p uses bits [p*ADDR_W +: ADDR_W] |
| wrData | input | WR_PORTS*DATA_W | Write data; port p uses bits [p*DATA_W +: DATA_W] |
| wrPoison | input | WR_PORTS | Poison bit written alongside the data, one bit per port |
| rdAddr | input | RD_PORTS*ADDR_W | Read addresses; port r uses bits [r*ADDR_W +: ADDR_W] |
| rdData | output | RD_PORTS*DATA_W | Read data; port r drives bits [r*DATA_W +: DATA_W] |
| rdPoison | output | RD_PORTS | Poison bit returned with each read port's data |
| wrConflict | output | 1 | High during a cycle in which two enabled writers share an address |

## Verification
The bench builds the block with its default parameters: 32 entries, 64-bit words, nine read ports and four write ports. With four write ports, every clash shape can be driven: two, three or four enabled writers on one entry, and a clash next to a disabled port that carries the same address. Nine read ports are enough to read back a whole set of distinct entries in one cycle, and a wide word lets walking and all-ones data patterns show up a lane that is dropped or swapped. During random traffic, the write addresses are often squeezed into a few entries. This makes multi-writer clashes and bypass hits frequent, and the bench compares the results against a behavioural scoreboard.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  // Summary strobes passed from the write control to the storage datapath.
  typedef struct packed {
    logic anyWrite;  // at least one write port enabled this cycle
    logic collide;   // two or more enabled write ports share an address
  } wrFlags_t;

endpackage

// File: rtl/regfile_wr_ctrl.sv
module regfile_wr_ctrl
  import regfile_pkg::*;
#(
  parameter int ENTRIES  = 32,
  parameter int WR_PORTS = 4,
  parameter int ADDR_W   = $clog2(ENTRIES),
  parameter int SEL_W    = (WR_PORTS > 1) ? $clog2(WR_PORTS) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [WR_PORTS-1:0]        wrEn,
  input  logic [WR_PORTS*ADDR_W-1:0] wrAddr,
  output logic [ENTRIES-1:0]         entWe,
  output logic [ENTRIES*SEL_W-1:0]   entSel,
  output wrFlags_t                   flags
);

  // Per-entry winner decode. Ports are scanned from low to high, so a
  // later (higher-numbered) enabled port overrides an earlier one.
  always_comb begin
    entWe  = '0;
    entSel = '0;
    for (int p = 0; p < WR_PORTS; p++) begin
      if (wrEn[p]) begin
        entWe[wrAddr[p*ADDR_W +: ADDR_W]] = 1'b1;
        entSel[wrAddr[p*ADDR_W +: ADDR_W]*SEL_W +: SEL_W] = SEL_W'(p);
      end
    end
  end

  // Pairwise clash detection between enabled write ports.
  always_comb begin
    flags.collide  = 1'b0;
    flags.anyWrite = |wrEn;
    for (int p = 0; p < WR_PORTS; p++) begin
      for (int q = p + 1; q < WR_PORTS; q++) begin
        if (wrEn[p] && wrEn[q] &&
            (wrAddr[p*ADDR_W +: ADDR_W] == wrAddr[q*ADDR_W +: ADDR_W]))
          flags.collide = 1'b1;
      end
    end
  end

  // R8
  conflict_needs_two_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags.collide |-> ($countones(wrEn) >= 2));

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_winChk
      logic [SEL_W-1:0] selE;
      assign selE = entSel[e*SEL_W +: SEL_W];
      // R6
      winner_match_chk: assert property (@(posedge clk) disable iff (!rstN)
        entWe[e] |-> (wrEn[selE] &&
                      (wrAddr[int'(selE)*ADDR_W +: ADDR_W] == ADDR_W'(e))));
    end
  endgenerate

endmodule

// File: rtl/regfile_store.sv
module regfile_store
  import regfile_pkg::*;
#(
  parameter int ENTRIES  = 32,
  parameter int DATA_W   = 64,
  parameter int RD_PORTS = 9,
  parameter int WR_PORTS = 4,
  parameter int ADDR_W   = $clog2(ENTRIES),
  parameter int SEL_W    = (WR_PORTS > 1) ? $clog2(WR_PORTS) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ENTRIES-1:0]         entWe,
  input  logic [ENTRIES*SEL_W-1:0]   entSel,
  input  wrFlags_t                   flags,
  input  logic [WR_PORTS*DATA_W-1:0] wrData,
  input  logic [WR_PORTS-1:0]        wrPoison,
  input  logic [RD_PORTS*ADDR_W-1:0] rdAddr,
  output logic [RD_PORTS*DATA_W-1:0] rdData,
  output logic [RD_PORTS-1:0]        rdPoison
);

  // The poison bit is kept as the top bit of each stored word.
  localparam int WORD_W = DATA_W + 1;

  logic [WORD_W-1:0] mem     [ENTRIES];
  logic [WORD_W-1:0] wrWord  [WR_PORTS];
  logic [WORD_W-1:0] winWord [ENTRIES];

  generate
    for (genvar p = 0; p < WR_PORTS; p++) begin : g_wrWord
      assign wrWord[p] = {wrPoison[p], wrData[p*DATA_W +: DATA_W]};
    end

    // One winning word per entry, shared by the update and the bypass.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_win
      assign winWord[e] = wrWord[entSel[e*SEL_W +: SEL_W]];

      // R3
      hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        !entWe[e] |=> $stable(mem[e]));
      // R2
      write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
        entWe[e] |=> (mem[e] == $past(winWord[e])));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++)
        if (entWe[e]) mem[e] <= winWord[e];
    end
  end

  generate
    for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
      logic [ADDR_W-1:0] addrR;
      logic [WORD_W-1:0] wordR;
      assign addrR = rdAddr[r*ADDR_W +: ADDR_W];

      always_comb begin
        if (entWe[addrR]) wordR = winWord[addrR];
        else              wordR = mem[addrR];
      end

      assign rdData[r*DATA_W +: DATA_W] = wordR[DATA_W-1:0];
      assign rdPoison[r]                = wordR[DATA_W];

      // R4
      read_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
        !flags.anyWrite |->
          ({rdPoison[r], rdData[r*DATA_W +: DATA_W]} == mem[addrR]));
    end
  endgenerate

endmodule

// File: rtl/regfile_mp.sv
module regfile_mp
  import regfile_pkg::*;
#(
  parameter int ENTRIES  = 32,
  parameter int DATA_W   = 64,
  parameter int RD_PORTS = 9,
  parameter int WR_PORTS = 4,
  localparam int ADDR_W  = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [WR_PORTS-1:0]        wrEn,
  input  logic [WR_PORTS*ADDR_W-1:0] wrAddr,
  input  logic [WR_PORTS*DATA_W-1:0] wrData,
  input  logic [WR_PORTS-1:0]        wrPoison,
  input  logic [RD_PORTS*ADDR_W-1:0] rdAddr,
  output logic [RD_PORTS*DATA_W-1:0] rdData,
  output logic [RD_PORTS-1:0]        rdPoison,
  output logic                       wrConflict
);

  localparam int SEL_W = (WR_PORTS > 1) ? $clog2(WR_PORTS) : 1;

  logic [ENTRIES-1:0]       entWe;
  logic [ENTRIES*SEL_W-1:0] entSel;
  wrFlags_t                 flags;

  regfile_wr_ctrl #(
    .ENTRIES (ENTRIES),
    .WR_PORTS(WR_PORTS),
    .ADDR_W  (ADDR_W),
    .SEL_W   (SEL_W)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .entWe (entWe),
    .entSel(entSel),
    .flags (flags)
  );

  regfile_store #(
    .ENTRIES (ENTRIES),
    .DATA_W  (DATA_W),
    .RD_PORTS(RD_PORTS),
    .WR_PORTS(WR_PORTS),
    .ADDR_W  (ADDR_W),
    .SEL_W   (SEL_W)
  ) u_store (
    .clk     (clk),
    .rstN    (rstN),
    .entWe   (entWe),
    .entSel  (entSel),
    .flags   (flags),
    .wrData  (wrData),
    .wrPoison(wrPoison),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .rdPoison(rdPoison)
  );

  assign wrConflict = flags.collide;

endmodule

// File: tb/regfile_mp_test.sv
module regfile_mp_test;

  localparam int NE = 32;
  localparam int DW = 64;
  localparam int NR = 9;
  localparam int NW = 4;
  localparam int AW = $clog2(NE);
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 3000;

  typedef struct packed {
    logic [1:0]    port;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          pois;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 5'd0,  64'h0123_4567_89AB_CDEF, 1'b0},
    '{2'd1, 5'd31, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
    '{2'd2, 5'd17, 64'h8000_0000_0000_0001, 1'b0},
    '{2'd3, 5'd6,  64'hDEAD_BEEF_0000_1111, 1'b1},
    '{2'd0, 5'd31, 64'h0000_0000_0000_0002, 1'b0},
    '{2'd3, 5'd1,  64'h5555_AAAA_5555_AAAA, 1'b0},
    '{2'd1, 5'd20, 64'hCAFE_0000_F00D_0000, 1'b1},
    '{2'd2, 5'd0,  64'h7FFF_FFFF_FFFF_FFFE, 1'b1}
  };

  logic             clk = 1'b0;
  logic             rstN;
  logic [NW-1:0]    wrEn;
  logic [NW*AW-1:0] wrAddr;
  logic [NW*DW-1:0] wrData;
  logic [NW-1:0]    wrPoison;
  logic [NR*AW-1:0] rdAddr;
  logic [NR*DW-1:0] rdData;
  logic [NR-1:0]    rdPoison;
  logic             wrConflict;

  logic [DW-1:0] sbData [NE];
  logic          sbPois [NE];
  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regfile_mp #(.ENTRIES(NE), .DATA_W(DW), .RD_PORTS(NR), .WR_PORTS(NW)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrPoison(wrPoison), .rdAddr(rdAddr), .rdData(rdData),
    .rdPoison(rdPoison), .wrConflict(wrConflict)
  );

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearWr();
    wrEn = '0; wrAddr = '0; wrData = '0; wrPoison = '0;
  endtask

  task automatic setWr(input int p, input logic en, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic ps);
    wrEn[p] = en;
    wrAddr[p*AW +: AW] = a;
    wrData[p*DW +: DW] = d;
    wrPoison[p] = ps;
  endtask

  // Scoreboard follows the rising edge: higher ports applied last win.
  task automatic tick();
    for (int p = 0; p < NW; p++)
      if (wrEn[p]) begin
        sbData[wrAddr[p*AW +: AW]] = wrData[p*DW +: DW];
        sbPois[wrAddr[p*AW +: AW]] = wrPoison[p];
      end
    @(negedge clk);
  endtask

  function automatic void expRead(input logic [AW-1:0] a,
                                  output logic [DW-1:0] d, output logic ps);
    d  = sbData[a];
    ps = sbPois[a];
    for (int p = 0; p < NW; p++)
      if (wrEn[p] && wrAddr[p*AW +: AW] == a) begin
        d  = wrData[p*DW +: DW];
        ps = wrPoison[p];
      end
  endfunction

  function automatic logic expConflict();
    logic c = 1'b0;
    for (int p = 0; p < NW; p++)
      for (int q = p + 1; q < NW; q++)
        if (wrEn[p] && wrEn[q] && wrAddr[p*AW +: AW] == wrAddr[q*AW +: AW])
          c = 1'b1;
    return c;
  endfunction

  task automatic checkAllReads(input string req);
    logic [DW-1:0] d;
    logic ps;
    for (int r = 0; r < NR; r++) begin
      expRead(rdAddr[r*AW +: AW], d, ps);
      check(req, rdData[r*DW +: DW], d);
      check(req, DW'(rdPoison[r]), DW'(ps));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < NE; e++) begin sbData[e] = '0; sbPois[e] = 1'b0; end
    rstN = 1'b0;
    clearWr();
    rdAddr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: every entry reads zero after reset
    for (int b = 0; b < NE; b += NR) begin
      for (int r = 0; r < NR; r++) rdAddr[r*AW +: AW] = AW'((b + r) % NE);
      #1;
      for (int r = 0; r < NR; r++) begin
        check("R1 data", rdData[r*DW +: DW], '0);
        check("R1 poison", DW'(rdPoison[r]), '0);
      end
      check("R1 conflict", DW'(wrConflict), '0);
      @(negedge clk);
    end

    // Vector table: single writer, bypass then stored readback
    for (int i = 0; i < 8; i++) begin
      clearWr();
      setWr(int'(VECS[i].port), 1'b1, VECS[i].addr, VECS[i].data, VECS[i].pois);
      rdAddr = '0;
      rdAddr[(i % NR)*AW +: AW] = VECS[i].addr;
      #1;
      check("R5 bypass data", rdData[(i % NR)*DW +: DW], VECS[i].data);
      check("R9 bypass poison", DW'(rdPoison[i % NR]), DW'(VECS[i].pois));
      check("R8 single writer", DW'(wrConflict), '0);
      tick();
      clearWr();
      #1;
      check("R2 stored data", rdData[(i % NR)*DW +: DW], VECS[i].data);
      check("R9 stored poison", DW'(rdPoison[i % NR]), DW'(VECS[i].pois));
      check("R4 quiet read", rdData[(i % NR)*DW +: DW], sbData[VECS[i].addr]);
    end

    // R3: disabled port ignored (entry 17 holds 8000...0001, poison 0)
    clearWr();
    setWr(1, 1'b0, 5'd17, 64'h1111_2222_3333_4444, 1'b1);
    rdAddr[0 +: AW] = 5'd17;
    #1;
    check("R3 no bypass data", rdData[0 +: DW], 64'h8000_0000_0000_0001);
    check("R3 no bypass poison", DW'(rdPoison[0]), '0);
    tick();
    #1;
    check("R3 entry unchanged", rdData[0 +: DW], 64'h8000_0000_0000_0001);
    check("R3 poison unchanged", DW'(rdPoison[0]), '0);

    // R6 R7 R8: ports 0,1,3 clash on entry 9, port 2 alone on entry 10
    clearWr();
    setWr(0, 1'b1, 5'd9,  64'hA0A0_A0A0_A0A0_A0A0, 1'b0);
    setWr(1, 1'b1, 5'd9,  64'hB1B1_B1B1_B1B1_B1B1, 1'b0);
    setWr(2, 1'b1, 5'd10, 64'hC2C2_C2C2_C2C2_C2C2, 1'b0);
    setWr(3, 1'b1, 5'd9,  64'hD3D3_D3D3_D3D3_D3D3, 1'b1);
    rdAddr[0 +: AW] = 5'd9;
    rdAddr[AW +: AW] = 5'd10;
    #1;
    check("R7 bypass winner", rdData[0 +: DW], 64'hD3D3_D3D3_D3D3_D3D3);
    check("R7 bypass winner poison", DW'(rdPoison[0]), 64'd1);
    check("R5 other port bypass", rdData[DW +: DW], 64'hC2C2_C2C2_C2C2_C2C2);
    check("R8 clash flagged", DW'(wrConflict), 64'd1);
    tick();
    clearWr();
    #1;
    check("R6 stored winner", rdData[0 +: DW], 64'hD3D3_D3D3_D3D3_D3D3);
    check("R6 stored winner poison", DW'(rdPoison[0]), 64'd1);
    check("R2 lone writer", rdData[DW +: DW], 64'hC2C2_C2C2_C2C2_C2C2);
    check("R8 flag drops", DW'(wrConflict), '0);

    // R6 R7: highest port disabled, so port 1 wins
    setWr(0, 1'b1, 5'd12, 64'h0000_0000_0000_00AA, 1'b1);
    setWr(1, 1'b1, 5'd12, 64'h0000_0000_0000_00BB, 1'b0);
    setWr(3, 1'b0, 5'd12, 64'h0000_0000_0000_00DD, 1'b1);
    rdAddr[0 +: AW] = 5'd12;
    #1;
    check("R7 disabled top ignored", rdData[0 +: DW], 64'h0000_0000_0000_00BB);
    check("R8 two enabled", DW'(wrConflict), 64'd1);
    tick();
    clearWr();
    #1;
    check("R6 stored port1", rdData[0 +: DW], 64'h0000_0000_0000_00BB);
    check("R6 stored port1 poison", DW'(rdPoison[0]), '0);

    // R8: same address with one port disabled is not a clash
    setWr(0, 1'b1, 5'd14, 64'h1, 1'b0);
    setWr(1, 1'b0, 5'd14, 64'h2, 1'b0);
    setWr(2, 1'b1, 5'd15, 64'h3, 1'b0);
    #1;
    check("R8 disabled not counted", DW'(wrConflict), '0);
    tick();
    clearWr();

    // R10: nine distinct addresses at once
    begin
      logic [AW-1:0] addrs [NR] = '{5'd0, 5'd31, 5'd17, 5'd6, 5'd1,
                                    5'd20, 5'd9, 5'd12, 5'd14};
      for (int r = 0; r < NR; r++) rdAddr[r*AW +: AW] = addrs[r];
      #1;
      checkAllReads("R10 distinct reads");
      tick();
    end

    // Random concurrent traffic against the scoreboard
    for (int c = 0; c < RAND_CYCLES; c++) begin
      int span = (c % 3 == 0) ? NE : 4;
      clearWr();
      for (int p = 0; p < NW; p++)
        setWr(p, 1'($urandom % 2), AW'($urandom % span),
              {$urandom, $urandom}, 1'($urandom % 2));
      for (int r = 0; r < NR; r++)
        rdAddr[r*AW +: AW] = AW'($urandom % span);
      #1;
      checkAllReads("R5 R7 random read");
      check("R8 random conflict", DW'(wrConflict), DW'(expConflict()));
      tick();
    end

    // Final sweep of stored state with writes idle
    clearWr();
    for (int b = 0; b < NE; b += NR) begin
      for (int r = 0; r < NR; r++) rdAddr[r*AW +: AW] = AW'((b + r) % NE);
      #1;
      checkAllReads("R6 R9 final sweep");
      @(negedge clk);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule